// File: doc/BRIEF.md
# Debug Power and Reset Status Register

This block is a 32-bit read-only status word that an external debugger reads at offset 0x314 of the debug register window. It reports the live state of a processor core: whether the core domain can be reached, whether the non-debug logic is in reset, whether the core is halted, and the lock states. It also keeps sticky flags. These flags latch events that the debugger might otherwise miss: loss of debug state, a core reset, a restart out of the halted state, and refused external accesses.

The same block decides whether an external access to one of three guarded register classes is refused. The classes are debug, performance monitor and trace. Each class has a two-bit control pair. The pair and the requester's security state together give a refuse signal. That signal serves as the bus error response and also sets the class's sticky error flag. A read of the status word returns the value as it stood before the read. Any clearing takes effect on the following clock edge, and only while the core domain is reachable.

Top module: `dbg_pwr_status`

## Requirements
- R1: Bit 0 (reachable) reads 1 exactly when `core_pwr_ok` is 1 and `dbl_lock` is 0. Bit 6 (double lock) reads 1 exactly when both `dbl_lock` and `core_pwr_ok` are 1.
- R2: The live bits are as follows. Bit 2 follows `core_in_reset`. Bit 4 reads 1 when `core_halted` is 1 and the core is not in reset. Bit 5 follows `os_lock`. The control pairs appear as debug {22,7}, performance monitor {20,10} and trace {21,14}, upper bit first. Every bit not assigned by a requirement reads 0. `bus_rdata` is 0 unless `bus_rd` is high with `bus_addr` equal to 0x314.
- R3: Bit 1 (state lost) sets when `state_lost` is high. A read clears it only while bit 0 is 1.
- R4: Bit 3 (reset seen) sets in every cycle in which `core_in_reset` is high. A read clears it only when bit 0 is 1 and bit 2 is 0.
- R5: Bit 11 (restarted) sets when the effective halted state, as reported in bit 4, goes from 1 to 0. This includes a core reset taken while halted. A read clears it only while bit 0 is 1.
- R6: `req_deny` is high for a valid request to a guarded class when its {ext, base} pair refuses the requester's security state. Classes are encoded 0 debug, 1 performance monitor, 2 trace and 3 unguarded. Security states are encoded 0 secure, 1 non-secure, 2 root and 3 realm. Pair 00 refuses nothing. Pair 01 refuses realm and non-secure. Pair 10 refuses secure and non-secure. Pair 11 refuses secure, non-secure and realm. Root is never refused.
- R7: A refused request sets sticky bit 8 (debug), bit 12 (performance monitor) or bit 15 (trace) on the next edge. A read clears these bits only while bit 0 is 1.
- R8: A read returns the value held before the read, and the clearing shows from the next cycle. If a set event and a clearing read fall in the same cycle, the bit ends up set.
- R9: Bus writes change no state and drive `bus_rdata` to 0.
- R10: After `rst_n` is released, bits 1 and 3 are 1 and all other sticky bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the status logic |
| core_pwr_ok | input | 1 | Core domain powered |
| core_in_reset | input | 1 | Non-debug core logic held in reset |
| core_halted | input | 1 | Core in halted (debug) state |
| os_lock | input | 1 | OS lock status |
| dbl_lock | input | 1 | Double-lock status |
| state_lost | input | 1 | Pulse: debug state in core domain lost |
| ctl_dbg | input | 2 | Debug class refuse pair {ext, base} |
| ctl_pmu | input | 2 | Performance monitor class refuse pair |
| ctl_trc | input | 2 | Trace class refuse pair |
| req_valid | input | 1 | External access request to a class |
| req_class | input | 2 | Class of the request |
| req_sec | input | 2 | Requester security state |
| req_deny | output | 1 | Request refused (error response) |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data (discarded) |
| bus_rdata | output | 32 | Read data |

## Verification
Two things can fall in the same cycle: a clearing read and an event that sets the same sticky bit. The bench raises `state_lost` in the very cycle that the status word is read while bit 1 is 0. It expects the read to return the old value and the next read to show bit 1 set. It also drives reads while the core domain is down, or while the core is in reset, and expects the sticky bits to survive those reads.

// File: rtl/dbg_pwr_status.sv
module dbg_pwr_status #(
  parameter int              AW         = 12,
  parameter logic [AW-1:0]   REG_OFFSET = 12'h314,
  parameter int              NCLS       = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        core_pwr_ok,
  input  logic        core_in_reset,
  input  logic        core_halted,
  input  logic        os_lock,
  input  logic        dbl_lock,
  input  logic        state_lost,
  input  logic [1:0]  ctl_dbg,
  input  logic [1:0]  ctl_pmu,
  input  logic [1:0]  ctl_trc,
  input  logic        req_valid,
  input  logic [1:0]  req_class,
  input  logic [1:0]  req_sec,
  output logic        req_deny,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam logic [1:0] SEC_S = 2'd0, SEC_NS = 2'd1, SEC_ROOT = 2'd2, SEC_RL = 2'd3;

  function automatic logic refused(input logic [1:0] ctl, input logic [1:0] sec);
    case (sec)
      SEC_S:   refused = ctl[1];
      SEC_NS:  refused = |ctl;
      SEC_RL:  refused = ctl[0];
      default: refused = 1'b0;
    endcase
  endfunction

  logic [NCLS-1:0][1:0] ctl;
  logic [NCLS-1:0]      deny_v, err_q;
  logic spd_q, sr_q, sdr_q, halted_q;
  logic [31:0] st;

  assign ctl = {ctl_trc, ctl_pmu, ctl_dbg};

  wire pu       = core_pwr_ok & ~dbl_lock;
  wire eff_halt = core_halted & ~core_in_reset;
  wire rd_hit   = bus_rd & (bus_addr == REG_OFFSET);
  wire clr      = rd_hit & pu;
  wire unused_wr = ^{bus_wr, bus_wdata};

  for (genvar i = 0; i < NCLS; i++) begin : g_cls
    assign deny_v[i] = req_valid && (req_class == 2'(i)) && refused(ctl[i], req_sec);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) err_q[i] <= 1'b0;
      else        err_q[i] <= deny_v[i] | (err_q[i] & ~clr);
  end

  assign req_deny = |deny_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_q    <= 1'b1;
      sr_q     <= 1'b1;
      sdr_q    <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      halted_q <= eff_halt;
      spd_q    <= state_lost | (spd_q & ~clr);
      sr_q     <= core_in_reset | (sr_q & ~(clr & ~core_in_reset));
      sdr_q    <= (halted_q & ~eff_halt) | (sdr_q & ~clr);
    end
  end

  always_comb begin
    st     = '0;
    st[0]  = pu;
    st[1]  = spd_q;
    st[2]  = core_in_reset;
    st[3]  = sr_q;
    st[4]  = eff_halt;
    st[5]  = os_lock;
    st[6]  = dbl_lock & core_pwr_ok;
    st[7]  = ctl_dbg[0];
    st[8]  = err_q[0];
    st[10] = ctl_pmu[0];
    st[11] = sdr_q;
    st[12] = err_q[1];
    st[14] = ctl_trc[0];
    st[15] = err_q[2];
    st[20] = ctl_pmu[1];
    st[21] = ctl_trc[1];
    st[22] = ctl_dbg[1];
  end

  assign bus_rdata = rd_hit ? st : '0;

  a_r1_pu_dlk_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> !(bus_rdata[0] && bus_rdata[6]));
  a_r3_spd_kept_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !core_pwr_ok && spd_q) |=> spd_q);
  a_r4_sr_kept_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_reset |=> sr_q);
  a_r5_exit_sets_sdr: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !eff_halt) |=> sdr_q);
  a_r6_root_never_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sec == SEC_ROOT) |-> !req_deny);
  a_r7_deny_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    req_deny |=> |err_q);
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state_lost && rd_hit) |=> spd_q);
  a_r9_write_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd) |-> bus_rdata == 32'h0);

endmodule

// File: tb/dbg_pwr_status_bench.sv
module dbg_pwr_status_bench;
  logic clk = 0, rst_n = 0;
  logic core_pwr_ok = 1, core_in_reset = 0, core_halted = 0, os_lock = 0, dbl_lock = 0, state_lost = 0;
  logic [1:0] ctl_dbg = 0, ctl_pmu = 0, ctl_trc = 0, req_class = 0, req_sec = 0;
  logic req_valid = 0, req_deny, bus_rd = 0, bus_wr = 0;
  logic [11:0] bus_addr = 12'h314;
  logic [31:0] bus_wdata = 0, bus_rdata, v;
  int errs = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbg_pwr_status u_dbg_pwr_status (.*);

  // {class, sec, ctl pair, expected refuse}
  localparam logic [6:0] VEC [12] = '{
    {2'd0, 2'd1, 2'b00, 1'b0}, {2'd0, 2'd1, 2'b01, 1'b1}, {2'd0, 2'd3, 2'b01, 1'b1},
    {2'd0, 2'd0, 2'b01, 1'b0}, {2'd0, 2'd2, 2'b01, 1'b0}, {2'd1, 2'd0, 2'b10, 1'b1},
    {2'd1, 2'd3, 2'b10, 1'b0}, {2'd1, 2'd1, 2'b10, 1'b1}, {2'd2, 2'd3, 2'b11, 1'b1},
    {2'd2, 2'd2, 2'b11, 1'b0}, {2'd2, 2'd0, 2'b11, 1'b1}, {2'd3, 2'd1, 2'b11, 1'b0}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic rd(output logic [31:0] r);
    bus_addr = 12'h314; bus_rd = 1; #1 r = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rdchk(input string req, input logic [31:0] exp);
    logic [31:0] r;
    rd(r); chk(req, r, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    // R10: reset values with reachable core
    rdchk("R10", 32'h0000_000B);
    rdchk("R10 cleared", 32'h0000_0001);

    // R6 table
    foreach (VEC[i]) begin
      req_class = VEC[i][6:5]; req_sec = VEC[i][4:3];
      ctl_dbg = VEC[i][2:1]; ctl_pmu = VEC[i][2:1]; ctl_trc = VEC[i][2:1];
      req_valid = 1; #1 chk("R6", {31'b0, req_deny}, {31'b0, VEC[i][0]});
      step();
    end
    req_valid = 0; ctl_dbg = 0; ctl_pmu = 0; ctl_trc = 0;
    rd(v);

    // R4 reset seen, kept while in reset
    core_in_reset = 1; step();
    rdchk("R4 in reset", 32'h0000_000D);
    core_in_reset = 0;
    rdchk("R4 held", 32'h0000_0009);
    rdchk("R4 cleared", 32'h0000_0001);

    // R5 restart
    core_halted = 1; step();
    rdchk("R2 halted live", 32'h0000_0011);
    core_halted = 0; step();
    rdchk("R5 exit", 32'h0000_0801);
    rdchk("R5 cleared", 32'h0000_0001);
    core_halted = 1; step();
    core_in_reset = 1; step();
    core_in_reset = 0; core_halted = 0;
    rdchk("R5 reset while halted", 32'h0000_0809);
    rdchk("R5 cleared after reset", 32'h0000_0001);

    // R3 state lost while unpowered
    core_pwr_ok = 0; state_lost = 1; step(); state_lost = 0;
    rdchk("R3 unpowered", 32'h0000_0002);
    rdchk("R3 kept", 32'h0000_0002);
    core_pwr_ok = 1;
    rdchk("R3 powered", 32'h0000_0003);
    rdchk("R3 cleared", 32'h0000_0001);

    // R1 double lock
    dbl_lock = 1;
    rdchk("R1 locked powered", 32'h0000_0040);
    core_pwr_ok = 0;
    rdchk("R1 locked unpowered", 32'h0000_0000);
    core_pwr_ok = 1; dbl_lock = 0;

    // R7 sticky errors
    ctl_dbg = 2'b01; req_class = 0; req_sec = 1; req_valid = 1; step(); req_valid = 0;
    rdchk("R7 debug err", 32'h0000_0181);
    rdchk("R7 debug cleared", 32'h0000_0081);
    ctl_dbg = 0; ctl_pmu = 2'b10; req_class = 1; req_sec = 0; req_valid = 1; step(); req_valid = 0;
    rdchk("R7 pmu err", 32'h0010_1001);
    rdchk("R7 pmu cleared", 32'h0010_0001);
    ctl_pmu = 0; ctl_trc = 2'b11; req_class = 2; req_sec = 3; req_valid = 1; step(); req_valid = 0;
    rdchk("R7 trace err", 32'h0020_C001);
    ctl_trc = 0;
    rdchk("R7 trace cleared", 32'h0000_0001);

    // R8 set and clear in the same cycle
    state_lost = 1; rd(v); state_lost = 0;
    chk("R8 pre-clear value", v, 32'h0000_0001);
    rdchk("R8 set wins", 32'h0000_0003);
    rdchk("R8 cleared next", 32'h0000_0001);

    // R9 writes ignored
    bus_wr = 1; bus_wdata = '1; bus_addr = 12'h314; #1 chk("R9 rdata on write", bus_rdata, 0);
    step(); bus_wr = 0;
    rdchk("R9 no effect", 32'h0000_0001);
    bus_addr = 12'h310; bus_rd = 1; #1 chk("R2 other offset", bus_rdata, 0);
    step(); bus_rd = 0;

    // R2 mirrors
    os_lock = 1; ctl_pmu = 2'b11; ctl_trc = 2'b10;
    rdchk("R2 mirrors", 32'h0030_0421);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule